// File: doc/BRIEF.md
# Four-Wide In-Order Issue Stage with Register Scoreboard

This block sits between instruction fetch and the execution units of a superscalar core. Fetch hands it a bundle of one to four 32-bit instructions at a time. The bundle goes into an eight-entry circular queue, which smooths out the difference between the fetch rate and the issue rate. Each cycle, the issue logic looks at the four oldest queued instructions and sends as many as it can, in program order, to a fixed set of six execution units: two integer ALUs, two floating-point units, one branch unit and one load/store unit.

An instruction leaves the queue only if four conditions hold. A unit of its class must be free. None of its sources may wait on a pending write. Its destination must not already be pending. It must not overwrite a register that an older instruction in the same group reads. A scoreboard holds one pending bit for each architectural register. The bit is set when a writer issues and cleared by a completion tag from the unit that runs it. The issue logic itself holds each floating-point unit busy for the floating-point latency. The per-cycle issue count is brought out so that throughput can be measured.

Top module: `issue_dispatch`

## Requirements
- R1: The queue holds 8 instructions. `fetch_ready` is 1 exactly when at least 4 entries are free. A bundle presented while `fetch_ready` is 0 is dropped.
- R2: Slot k of `fetch_word` is bits [32k+31:32k], and slot 0 is the oldest. Only the slots below `fetch_cnt` (1 to 4) are queued, and they are queued in slot order.
- R3: Issue is strictly in program order. Once the oldest unissued instruction is blocked, no younger instruction issues in that cycle.
- R4: Instruction fields are: class [31:30] (0 integer, 1 floating point, 2 branch, 3 load/store), write flag [29], destination [28:24], source A [23:19], source B [18:14]. Unit bits of `iss_valid` are: 0 and 1 ALUs, 2 and 3 FPUs, 4 branch, 5 load/store. Within a class, the lowest-numbered free unit is taken first. The issued word appears in `iss_word` at bits [32u+31:32u].
- R5: At most 4 instructions issue per cycle. `issue_cnt` equals the number of bits set in `iss_valid`.
- R6: An instruction does not issue while either of its sources is pending or is written by an older instruction in the same group.
- R7: A writing instruction does not issue while its destination is pending or is written by an older instruction in the same group.
- R8: A writing instruction does not issue if an older instruction in the same group reads its destination.
- R9: After an issue to a floating-point unit, that unit takes no new instruction for the next 2 cycles (latency 3).
- R10: A writing instruction marks its destination pending from the cycle after issue. A completion tag (`cmp_valid` bit with `cmp_reg` field) clears the bit from the cycle after.
- R11: A unit whose `unit_busy` bit is 1 receives no instruction.
- R12: After reset the queue is empty, no register is pending, `fetch_ready` is 1 and nothing issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetch bundle is present |
| fetch_cnt | input | 3 | Number of valid slots in the bundle, 1 to 4 |
| fetch_word | input | 128 | Four 32-bit instruction slots, slot 0 oldest |
| fetch_ready | output | 1 | Queue can take a full bundle |
| unit_busy | input | 6 | Per-unit busy from the execution units |
| cmp_valid | input | 4 | Completion tag valid, one per write-back port |
| cmp_reg | input | 20 | Completed destination register, 5 bits per port |
| iss_valid | output | 6 | Instruction sent to the unit this cycle |
| iss_word | output | 192 | Instruction word for each unit |
| issue_cnt | output | 3 | Instructions issued this cycle |

## Verification
The assertions assume that completion tags name only registers that are currently pending. They also assume that no tag arrives in the same cycle as a new writer to the same register. The stimulus meets both conditions: it returns tags only for destinations that have already issued, and it does so only after checking the issue cycle. The assertions also assume `fetch_cnt` stays between 1 and 4 whenever `fetch_valid` is high. Every bundle in the bench follows this.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int XLEN  = 32;
  localparam int RW    = 5;
  localparam int NREG  = 1 << RW;
  localparam int NUNIT = 6;
  localparam int NFP   = 2;

  typedef enum logic [1:0] {CL_INT = 2'd0, CL_FP = 2'd1, CL_BR = 2'd2, CL_LS = 2'd3} cls_e;

  typedef struct packed {
    cls_e          cls;
    logic          wr;
    logic [RW-1:0] dst;
    logic [RW-1:0] sa;
    logic [RW-1:0] sb;
    logic [13:0]   rest;
  } ins_t;

  function automatic cls_e unit_class(int u);
    if (u < 2) return CL_INT;
    if (u < 4) return CL_FP;
    if (u == 4) return CL_BR;
    return CL_LS;
  endfunction

  // {found, index}: lowest free unit of the class
  function automatic logic [3:0] pick_unit(logic [NUNIT-1:0] avail, cls_e c);
    logic [3:0] r;
    r = '0;
    for (int u = NUNIT - 1; u >= 0; u--)
      if (avail[u] && unit_class(u) == c) r = {1'b1, 3'(u)};
    return r;
  endfunction

  function automatic logic reads_any(ins_t x, logic [NREG-1:0] m);
    return m[x.sa] | m[x.sb];
  endfunction

  function automatic logic writes_into(ins_t x, logic [NREG-1:0] m);
    return x.wr & m[x.dst];
  endfunction
endpackage

// File: rtl/dsp_queue.sv
module dsp_queue #(
  parameter int DEPTH = 8,
  parameter int W     = 4,
  parameter int DW    = 32,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int ICW  = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_valid,
  input  logic [ICW-1:0]  push_cnt,
  input  logic [W*DW-1:0] push_data,
  output logic            push_ready,
  input  logic [ICW-1:0]  pop_n,
  output logic [W*DW-1:0] head,
  output logic [ICW-1:0]  head_cnt
);
  logic [DW-1:0]   mem [DEPTH];
  logic [PTRW-1:0] rd_ptr, wr_ptr;
  logic [CNTW-1:0] count;
  logic            push_fire;

  assign push_ready = (CNTW'(DEPTH) - count) >= CNTW'(W);
  assign push_fire  = push_valid && push_ready && push_cnt != '0 && int'(push_cnt) <= W;
  assign head_cnt   = (count >= CNTW'(W)) ? ICW'(W) : ICW'(count);

  always_comb
    for (int i = 0; i < W; i++) head[i*DW +: DW] = mem[rd_ptr + PTRW'(i)];

  always_ff @(posedge clk)
    for (int i = 0; i < W; i++)
      if (push_fire && i < int'(push_cnt)) mem[wr_ptr + PTRW'(i)] <= push_data[i*DW +: DW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr + PTRW'(pop_n);
      wr_ptr <= wr_ptr + (push_fire ? PTRW'(push_cnt) : '0);
      count  <= count + (push_fire ? CNTW'(push_cnt) : '0) - CNTW'(pop_n);
    end
  end

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n) count <= CNTW'(DEPTH));
  a_r3_pop_le_avail: assert property (@(posedge clk) disable iff (!rst_n) pop_n <= head_cnt);
endmodule

// File: rtl/dsp_scoreboard.sv
module dsp_scoreboard import dsp_pkg::*; #(
  parameter int W      = 4,
  parameter int NCMP   = 4,
  parameter int FP_LAT = 3,
  localparam int CW    = $clog2(FP_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      set_en,
  input  logic [W*RW-1:0]   set_reg,
  input  logic [NCMP-1:0]   cmp_valid,
  input  logic [NCMP*RW-1:0] cmp_reg,
  input  logic [NFP-1:0]    fp_issue,
  output logic [NREG-1:0]   pending,
  output logic [NFP-1:0]    fp_busy
);
  logic [NREG-1:0] pend_nxt;

  always_comb begin
    pend_nxt = pending;
    for (int c = 0; c < NCMP; c++)
      if (cmp_valid[c]) pend_nxt[cmp_reg[c*RW +: RW]] = 1'b0;
    for (int i = 0; i < W; i++)
      if (set_en[i]) pend_nxt[set_reg[i*RW +: RW]] = 1'b1;
  end

  always_ff @(posedge clk)
    if (!rst_n) pending <= '0;
    else        pending <= pend_nxt;

  for (genvar i = 0; i < W; i++) begin : g_set
    a_r10_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
      set_en[i] |=> pending[$past(set_reg[i*RW +: RW])]);
  end

  for (genvar j = 0; j < NFP; j++) begin : g_fp
    logic [CW-1:0] left;
    always_ff @(posedge clk)
      if (!rst_n)           left <= '0;
      else if (fp_issue[j]) left <= CW'(FP_LAT - 1);
      else if (left != '0)  left <= left - CW'(1);
    assign fp_busy[j] = left != '0;
    if (FP_LAT > 1) begin : g_chk
      a_r9_fp_busy: assert property (@(posedge clk) disable iff (!rst_n) fp_issue[j] |=> fp_busy[j]);
    end
  end
endmodule

// File: rtl/dsp_select.sv
module dsp_select import dsp_pkg::*; #(
  parameter int W     = 4,
  localparam int ICW  = $clog2(W + 1)
) (
  input  logic [W*XLEN-1:0]     head,
  input  logic [ICW-1:0]        head_cnt,
  input  logic [NREG-1:0]       pending,
  input  logic [NUNIT-1:0]      unit_free,
  output logic [NUNIT-1:0]      iss_valid,
  output logic [NUNIT*XLEN-1:0] iss_word,
  output logic [ICW-1:0]        n_issue,
  output logic [W-1:0]          set_en,
  output logic [W*RW-1:0]       set_reg
);
  ins_t            ins;
  logic [NUNIT-1:0] avail;
  logic [NREG-1:0] g_wr, g_rd;
  logic            go, haz;
  logic [3:0]      pk;

  always_comb begin
    avail = unit_free;
    go = 1'b1; haz = 1'b0; pk = '0; ins = '0;
    g_wr = '0; g_rd = '0;
    iss_valid = '0; iss_word = '0; n_issue = '0; set_en = '0; set_reg = '0;
    for (int i = 0; i < W; i++) begin
      ins = ins_t'(head[i*XLEN +: XLEN]);
      haz = reads_any(ins, pending | g_wr) || writes_into(ins, pending | g_wr) || writes_into(ins, g_rd);
      pk  = pick_unit(avail, ins.cls);
      if (go && i < int'(head_cnt) && !haz && pk[3]) begin
        iss_valid[pk[2:0]] = 1'b1;
        iss_word[int'(pk[2:0])*XLEN +: XLEN] = ins;
        avail[pk[2:0]] = 1'b0;
        n_issue = n_issue + ICW'(1);
        set_en[i] = ins.wr;
        set_reg[i*RW +: RW] = ins.dst;
        if (ins.wr) g_wr[ins.dst] = 1'b1;
        g_rd[ins.sa] = 1'b1;
        g_rd[ins.sb] = 1'b1;
      end else begin
        go = 1'b0;
      end
    end
  end
endmodule

// File: rtl/issue_dispatch.sv
module issue_dispatch import dsp_pkg::*; #(
  parameter int QDEPTH = 8,
  parameter int WIDTH  = 4,
  parameter int NCMP   = 4,
  parameter int FP_LAT = 3,
  localparam int ICW   = $clog2(WIDTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fetch_valid,
  input  logic [ICW-1:0]         fetch_cnt,
  input  logic [WIDTH*XLEN-1:0]  fetch_word,
  output logic                   fetch_ready,
  input  logic [NUNIT-1:0]       unit_busy,
  input  logic [NCMP-1:0]        cmp_valid,
  input  logic [NCMP*RW-1:0]     cmp_reg,
  output logic [NUNIT-1:0]       iss_valid,
  output logic [NUNIT*XLEN-1:0]  iss_word,
  output logic [ICW-1:0]         issue_cnt
);
  logic [WIDTH*XLEN-1:0] head;
  logic [ICW-1:0]        head_cnt;
  logic [NREG-1:0]       pending;
  logic [NFP-1:0]        fp_busy;
  logic [NUNIT-1:0]      unit_free;
  logic [WIDTH-1:0]      set_en;
  logic [WIDTH*RW-1:0]   set_reg;

  assign unit_free = ~(unit_busy | {2'b00, fp_busy, 2'b00});

  dsp_queue #(.DEPTH(QDEPTH), .W(WIDTH), .DW(XLEN)) u_q (
    .clk(clk), .rst_n(rst_n), .push_valid(fetch_valid), .push_cnt(fetch_cnt),
    .push_data(fetch_word), .push_ready(fetch_ready), .pop_n(issue_cnt),
    .head(head), .head_cnt(head_cnt));

  dsp_select #(.W(WIDTH)) u_sel (
    .head(head), .head_cnt(head_cnt), .pending(pending), .unit_free(unit_free),
    .iss_valid(iss_valid), .iss_word(iss_word), .n_issue(issue_cnt),
    .set_en(set_en), .set_reg(set_reg));

  dsp_scoreboard #(.W(WIDTH), .NCMP(NCMP), .FP_LAT(FP_LAT)) u_sb (
    .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_reg(set_reg),
    .cmp_valid(cmp_valid), .cmp_reg(cmp_reg), .fp_issue(iss_valid[3:2]),
    .pending(pending), .fp_busy(fp_busy));

  a_r11_busy_respected: assert property (@(posedge clk) disable iff (!rst_n) (iss_valid & unit_busy) == '0);
  a_r5_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    int'(issue_cnt) == $countones(iss_valid) && int'(issue_cnt) <= WIDTH);
  if (FP_LAT > 1) begin : g_fpgap
    a_r9_fp_gap0: assert property (@(posedge clk) disable iff (!rst_n) iss_valid[2] |=> !iss_valid[2]);
    a_r9_fp_gap1: assert property (@(posedge clk) disable iff (!rst_n) iss_valid[3] |=> !iss_valid[3]);
  end
  for (genvar u = 0; u < NUNIT; u++) begin : g_src
    ins_t w;
    assign w = ins_t'(iss_word[u*XLEN +: XLEN]);
    a_r6_src_clear: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[u] |-> !pending[w.sa] && !pending[w.sb] && w.cls == unit_class(u));
  end
endmodule

// File: tb/issue_dispatch_test.sv
`timescale 1ns/1ps
module issue_dispatch_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fv = 1'b0;
  logic [2:0] fcnt = '0;
  logic [127:0] fword = '0;
  logic fready;
  logic [5:0] busy = '0;
  logic [3:0] cv = '0;
  logic [19:0] creg = '0;
  logic [5:0] ivalid;
  logic [191:0] iword;
  logic [2:0] icnt;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  logic [31:0] expq[$];

  always #2 clk = ~clk;

  issue_dispatch uut (.clk(clk), .rst_n(rst_n), .fetch_valid(fv), .fetch_cnt(fcnt),
    .fetch_word(fword), .fetch_ready(fready), .unit_busy(busy), .cmp_valid(cv),
    .cmp_reg(creg), .iss_valid(ivalid), .iss_word(iword), .issue_cnt(icnt));

  function automatic logic [31:0] mk(logic [1:0] c, logic w, int d, int a, int b, int id);
    return {c, w, 5'(d), 5'(a), 5'(b), 14'(id)};
  endfunction

  function automatic logic [1:0] ucls(int u);
    return (u < 2) ? 2'd0 : (u < 4) ? 2'd1 : (u == 4) ? 2'd2 : 2'd3;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_iss(string tag, int n, logic [5:0] mask);
    @(negedge clk);
    chk({tag, " issue_cnt"}, 32'(icnt), 32'(n));
    chk({tag, " iss_valid"}, 32'(ivalid), 32'(mask));
  endtask

  task automatic push(logic [31:0] a, logic [31:0] b, logic [31:0] c, logic [31:0] d, int n);
    step();
    fword = {d, c, b, a};
    fcnt = 3'(n);
    fv = 1'b1;
    if (fready) begin
      expq.push_back(a);
      if (n > 1) expq.push_back(b);
      if (n > 2) expq.push_back(c);
      if (n > 3) expq.push_back(d);
    end
    step();
    fv = 1'b0;
  endtask

  task automatic complete(logic [19:0] regs, logic [3:0] mask);
    step();
    creg = regs;
    cv = mask;
    step();
    cv = '0;
  endtask

  // monitor: issued words must leave in program order (R2 R3) on a unit of their class (R4)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < int'(icnt); k++) begin
        logic [31:0] w;
        bit hit;
        hit = 1'b0;
        w = (expq.size() > 0) ? expq.pop_front() : 32'hdeadbeef;
        for (int u = 0; u < 6; u++)
          if (ivalid[u] && iword[u*32 +: 32] == w && ucls(u) == w[31:30]) hit = 1'b1;
        nchk++;
        if (!hit) begin
          nerr++;
          $display("FAIL R3 order/unit actual_valid=%b expected_word=%0h", ivalid, w);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12 reset state
    @(negedge clk);
    chk("R12 fetch_ready", 32'(fready), 32'd1);
    chk("R12 issue_cnt", 32'(icnt), 32'd0);
    chk("R12 iss_valid", 32'(ivalid), 32'd0);

    // R5 R4: four independent instructions of different classes
    push(mk(0,1,1,0,0,1), mk(0,1,2,0,0,2), mk(3,1,3,0,0,3), mk(2,0,0,0,0,4), 4);
    expect_iss("R5", 4, 6'b110011);
    complete({5'd0, 5'd3, 5'd2, 5'd1}, 4'b0111);

    // R4: only two integer units
    push(mk(0,1,4,0,0,5), mk(0,1,5,0,0,6), mk(0,1,6,0,0,7), mk(0,1,7,0,0,8), 4);
    expect_iss("R4 first pair", 2, 6'b000011);
    step();
    expect_iss("R4 second pair", 2, 6'b000011);
    complete({5'd7, 5'd6, 5'd5, 5'd4}, 4'b1111);

    // R6 R10: read-after-write in group then against pending
    push(mk(0,1,8,0,0,9), mk(0,1,9,8,0,10), 0, 0, 2);
    expect_iss("R6 group", 1, 6'b000001);
    step();
    expect_iss("R10 pending set", 0, 6'b000000);
    step();
    creg = {15'd0, 5'd8};
    cv = 4'b0001;
    expect_iss("R6 still pending", 0, 6'b000000);
    step();
    cv = '0;
    expect_iss("R10 cleared", 1, 6'b000001);
    complete({15'd0, 5'd9}, 4'b0001);

    // R7: write-after-write
    push(mk(0,1,10,0,0,11), mk(3,1,10,0,0,12), 0, 0, 2);
    expect_iss("R7 group", 1, 6'b000001);
    step();
    creg = {15'd0, 5'd10};
    cv = 4'b0001;
    expect_iss("R7 pending", 0, 6'b000000);
    step();
    cv = '0;
    expect_iss("R7 released", 1, 6'b100000);
    complete({15'd0, 5'd10}, 4'b0001);

    // R8: write-after-read in group
    push(mk(0,1,12,11,0,13), mk(0,1,11,0,0,14), 0, 0, 2);
    expect_iss("R8 group", 1, 6'b000001);
    step();
    expect_iss("R8 next cycle", 1, 6'b000001);
    complete({10'd0, 5'd11, 5'd12}, 4'b0011);

    // R9: floating-point latency
    push(mk(1,1,13,0,0,15), mk(1,1,14,0,0,16), mk(1,1,15,0,0,17), mk(1,1,16,0,0,18), 4);
    expect_iss("R9 issue", 2, 6'b001100);
    step();
    expect_iss("R9 busy1", 0, 6'b000000);
    step();
    expect_iss("R9 busy2", 0, 6'b000000);
    step();
    expect_iss("R9 free", 2, 6'b001100);
    complete({5'd16, 5'd15, 5'd14, 5'd13}, 4'b1111);

    // R11 R3: busy load/store unit blocks it and younger work
    busy = 6'b100000;
    push(mk(3,1,17,0,0,19), mk(0,1,18,0,0,20), 0, 0, 2);
    expect_iss("R11 R3 blocked", 0, 6'b000000);
    step();
    busy = '0;
    expect_iss("R11 released", 2, 6'b100001);
    complete({10'd0, 5'd18, 5'd17}, 4'b0011);

    // R4 R11: busy ALU0 sends integer to ALU1
    busy = 6'b000001;
    push(mk(0,1,19,0,0,21), 0, 0, 0, 1);
    expect_iss("R4 lowest free", 1, 6'b000010);
    step();
    busy = '0;
    complete({15'd0, 5'd19}, 4'b0001);

    // R1: capacity and back-pressure
    busy = 6'b111111;
    push(mk(2,0,0,0,0,30), mk(2,0,0,0,0,31), mk(2,0,0,0,0,32), mk(2,0,0,0,0,33), 4);
    @(negedge clk);
    chk("R1 half full ready", 32'(fready), 32'd1);
    push(mk(2,0,0,0,0,34), mk(2,0,0,0,0,35), mk(2,0,0,0,0,36), mk(2,0,0,0,0,37), 4);
    @(negedge clk);
    chk("R1 full not ready", 32'(fready), 32'd0);
    push(mk(2,0,0,0,0,40), mk(2,0,0,0,0,41), mk(2,0,0,0,0,42), mk(2,0,0,0,0,43), 4);
    @(negedge clk);
    chk("R1 still not ready", 32'(fready), 32'd0);
    step();
    busy = '0;
    for (int k = 0; k < 8; k++) begin
      expect_iss("R1 drain", 1, 6'b010000);
      step();
    end
    expect_iss("R1 dropped bundle", 0, 6'b000000);
    chk("R1 ready after drain", 32'(fready), 32'd1);

    // R2: only fetch_cnt slots are taken
    push(mk(2,0,0,0,0,50), mk(2,0,0,0,0,51), mk(2,0,0,0,0,52), mk(0,1,30,0,0,53), 3);
    for (int k = 0; k < 3; k++) begin
      expect_iss("R2 partial", 1, 6'b010000);
      step();
    end
    expect_iss("R2 slot3 ignored", 0, 6'b000000);
    chk("R2 all consumed", 32'(expq.size()), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule